// File: doc/BRIEF.md
# Ethernet Link Bring-up Reset Sequencer

This block brings an Ethernet port core out of reset in a fixed order. It holds the core's active-low reset, waits for the core to acknowledge that reset, lets the reset go, then waits for the transmit lanes to settle and for the receive PCS to report ready. Only after all four steps does it raise one link-ready output. Each step moves on only when the core's own status says so. No step relies on a fixed delay.

Each waiting step is bounded by a cycle limit that is set on an input. If the limit runs out, the sequencer sets a sticky error, records which step stalled, and goes back to idle with the core held in reset. A later start pulse clears the error and runs the sequence again. If the link is up and either the transmit or the receive status drops, link-ready falls and the sequence restarts by putting the core back into reset. The three status inputs come from another clock domain, so each one passes through a two-flop synchronizer before it is used.

Top module: `eth_bringup_seq`

## Requirements
- R1: During and after reset, with no start seen, `core_rst_n_o` is 0, `link_ready_o` is 0, `err_o` is 0 and `err_stage_o` is 0.
- R2: A `start_i` pulse in idle begins the sequence. `core_rst_n_o` stays 0 until the synchronized `rst_ack_n_i` is 0, and it goes to 1 on the next clock edge after that.
- R3: Once the reset is released, the sequencer waits while the synchronized `tx_stable_i` is 0, with `link_ready_o` held at 0.
- R4: Once the transmit side is stable, the sequencer waits for the synchronized `rx_ready_i` to be 1, and then sets `link_ready_o` to 1.
- R5: Each wait step moves on early if its condition holds, and otherwise counts one per cycle from 0. When the count equals `tmo_limit_i` and the condition still does not hold, the next edge sets `err_o` to 1 and returns to idle with `core_rst_n_o` at 0. `err_stage_o` records the step that stalled: 1 = acknowledge, 2 = transmit stable, 3 = receive ready. The error stays set while idle.
- R6: A start accepted from idle clears `err_o` and sets `err_stage_o` to 0 on the same edge, and a new sequence runs.
- R7: While `link_ready_o` is 1, if the synchronized `tx_stable_i` or `rx_ready_i` is 0, the next edge clears `link_ready_o` and drives `core_rst_n_o` to 0. The sequence then restarts at the acknowledge wait.
- R8: A `start_i` pulse while a sequence is running, or while the link is up, has no effect.
- R9: Each status input reaches the control logic through two flops. A change on an input appears at the outputs on the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle request to begin bring-up |
| tmo_limit_i | input | TMO_W | Cycle limit for each wait step |
| rst_ack_n_i | input | 1 | Core reset acknowledge, active low, asynchronous |
| tx_stable_i | input | 1 | Core transmit lanes stable, asynchronous |
| rx_ready_i | input | 1 | Core receive PCS ready, asynchronous |
| core_rst_n_o | output | 1 | Active-low reset to the core |
| link_ready_o | output | 1 | Bring-up complete |
| err_o | output | 1 | Sticky timeout error |
| err_stage_o | output | 2 | Step that timed out (0 = none) |

## Verification
A change on a status input reaches the outputs on the third rising edge after it: two edges pass through the synchronizer and one more updates the state. A start pulse takes effect on the first edge. A wait step with limit L that never sees its condition raises the error on edge L+1 after entering the step. The bench drives inputs on the falling edge and waits an exact number of rising edges before it samples. For timeouts it samples once well before the due edge and once after it. In one table entry it samples the link one edge before it is due, to show the synchronizer delay.

// File: rtl/eth_bringup_seq.sv
module eth_bringup_seq #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  input  logic             rst_ack_n_i,
  input  logic             tx_stable_i,
  input  logic             rx_ready_i,
  output logic             core_rst_n_o,
  output logic             link_ready_o,
  output logic             err_o,
  output logic [1:0]       err_stage_o
);

  typedef enum logic [2:0] {S_IDLE, S_ACK, S_TX, S_RX, S_LINK} state_t;

  state_t           state;
  logic [1:0]       ack_q, tx_q, rx_q;
  logic             ack_s, tx_s, rx_s;
  logic [TMO_W-1:0] cnt;
  logic             expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 2'b11;
      tx_q  <= 2'b00;
      rx_q  <= 2'b00;
    end else begin
      ack_q <= {ack_q[0], rst_ack_n_i};
      tx_q  <= {tx_q[0], tx_stable_i};
      rx_q  <= {rx_q[0], rx_ready_i};
    end
  end

  assign ack_s   = ack_q[1];
  assign tx_s    = tx_q[1];
  assign rx_s    = rx_q[1];
  assign expired = (cnt == tmo_limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      err_o       <= 1'b0;
      err_stage_o <= 2'd0;
    end else begin
      cnt <= cnt + 1'b1;
      unique case (state)
        S_IDLE: begin
          cnt <= '0;
          if (start_i) begin
            state       <= S_ACK;
            err_o       <= 1'b0;
            err_stage_o <= 2'd0;
          end
        end
        S_ACK: begin
          if (!ack_s) begin
            state <= S_TX;
            cnt   <= '0;
          end else if (expired) begin
            state       <= S_IDLE;
            err_o       <= 1'b1;
            err_stage_o <= 2'd1;
          end
        end
        S_TX: begin
          if (tx_s) begin
            state <= S_RX;
            cnt   <= '0;
          end else if (expired) begin
            state       <= S_IDLE;
            err_o       <= 1'b1;
            err_stage_o <= 2'd2;
          end
        end
        S_RX: begin
          if (rx_s) begin
            state <= S_LINK;
            cnt   <= '0;
          end else if (expired) begin
            state       <= S_IDLE;
            err_o       <= 1'b1;
            err_stage_o <= 2'd3;
          end
        end
        S_LINK: begin
          cnt <= '0;
          if (!tx_s || !rx_s) state <= S_ACK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign core_rst_n_o = (state == S_TX) || (state == S_RX) || (state == S_LINK);
  assign link_ready_o = (state == S_LINK);

  AST_REL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_n_o) |-> !$past(ack_s)); // R2
  AST_LINK_NEEDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ready_o) |-> $past(rx_s) && core_rst_n_o); // R4
  AST_ERR_HAS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (err_stage_o != 2'd0) && !link_ready_o); // R5
  AST_ERR_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_o) |-> $past(start_i)); // R6
  AST_LINK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ready_o && !(tx_s && rx_s)) |=> !link_ready_o && !core_rst_n_o); // R7
  AST_LINK_HOLD_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ready_o && tx_s && rx_s) |=> link_ready_o); // R8

endmodule

// File: tb/eth_bringup_seq_bench.sv
module eth_bringup_seq_bench;
  localparam int TMO_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [TMO_W-1:0] tmo = 16'd1000;
  logic ack_n = 1'b1, tx = 1'b0, rx = 1'b0;
  logic core_rst_n, link, err;
  logic [1:0] stage;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  eth_bringup_seq #(.TMO_W(TMO_W)) u_eth_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .tmo_limit_i(tmo),
    .rst_ack_n_i(ack_n), .tx_stable_i(tx), .rx_ready_i(rx),
    .core_rst_n_o(core_rst_n), .link_ready_o(link),
    .err_o(err), .err_stage_o(stage));

  // {start, ack_n, tx, rx, cycles, exp core_rst_n, exp link, exp err}
  typedef struct packed {
    logic st, a, t, r;
    logic [7:0] cyc;
    logic e_rst, e_link, e_err;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'd3, 1'b0, 1'b0, 1'b0}, // R1 idle
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'd4, 1'b0, 1'b0, 1'b0}, // R2 held in reset
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'd3, 1'b1, 1'b0, 1'b0}, // R2 release, R9
    '{1'b0, 1'b0, 1'b1, 1'b0, 8'd3, 1'b1, 1'b0, 1'b0}, // R3 waiting rx
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd2, 1'b1, 1'b0, 1'b0}, // R9 not yet
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd1, 1'b1, 1'b1, 1'b0}, // R4 link up
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'd4, 1'b1, 1'b1, 1'b0}, // R8 start ignored
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd3, 1'b0, 1'b0, 1'b0}, // R7 tx drop
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd1, 1'b1, 1'b0, 1'b0}, // R7 restart past ack
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd6, 1'b1, 1'b1, 1'b0}  // R7 link again
  };

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    edges(1);
    start = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    edges(3);
    chk("R1 rst", core_rst_n, 0); chk("R1 link", link, 0);
    chk("R1 err", err, 0);        chk("R1 stage", stage, 0);
    rst_n = 1'b1;
    edges(2);

    for (int k = 0; k < 10; k++) begin
      ack_n = VECS[k].a; tx = VECS[k].t; rx = VECS[k].r;
      if (VECS[k].st) begin pulse_start(); edges(int'(VECS[k].cyc) - 1); end
      else edges(int'(VECS[k].cyc));
      chk($sformatf("vec%0d rst R2/R7", k), core_rst_n, VECS[k].e_rst);
      chk($sformatf("vec%0d link R4/R8", k), link, VECS[k].e_link);
      chk($sformatf("vec%0d err", k), err, VECS[k].e_err);
    end

    // R5 acknowledge timeout, code 1
    rst_n = 1'b0; ack_n = 1'b1; tx = 1'b0; rx = 1'b0; tmo = 16'd5;
    edges(2); rst_n = 1'b1; edges(3);
    pulse_start(); edges(3);
    chk("R5 no early err", err, 0);
    edges(4);
    chk("R5 ack err", err, 1); chk("R5 ack stage", stage, 1);
    chk("R5 back in reset", core_rst_n, 0);
    edges(10);
    chk("R5 sticky", err, 1);

    // R6 start clears, then transmit timeout code 2
    ack_n = 1'b0; edges(4);
    pulse_start();
    chk("R6 cleared", err, 0); chk("R6 stage cleared", stage, 0);
    edges(20);
    chk("R5 tx err", err, 1); chk("R5 tx stage", stage, 2);

    // receive timeout code 3
    tx = 1'b1; edges(4);
    pulse_start(); edges(30);
    chk("R5 rx err", err, 1); chk("R5 rx stage", stage, 3);
    chk("R5 rx link", link, 0);

    // R7 rx drop while up
    tmo = 16'd1000; rx = 1'b1; edges(4);
    pulse_start(); edges(4);
    chk("R4 link up", link, 1); chk("R6 err clear", err, 0);
    rx = 1'b0; edges(3);
    chk("R7 rx drop link", link, 0); chk("R7 rx drop reset", core_rst_n, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule